// File: doc/BRIEF.md
# Write Completion Status Reporter

This block decides which byte goes back to the host on a read of a byte-wide nonvolatile memory. While no internal write cycle runs, a read returns the array data on all eight bits and drives every bit. While an internal write cycle runs, the array path is replaced by a handshake byte. Its top bit polls completion and reads as the complement of the top bit of the last byte written. The next bit flips on each read and starts from zero in every cycle. The bit below that shows the page-load timer. The five low bits are left undriven.

Each read is a one-cycle strobe. The reply is registered, so it shows at the outputs one clock after the strobe and holds until the next strobe. A per-bit drive enable shows which data bits a pad would drive and which would float. The array storage and the write sequencer sit outside this block. They supply the busy flag, the timer state, the last written address and its top data bit, and the array read data.

Top module: `wr_status_rpt`

## Requirements
- R1: With `busy` low, a read returns `array_data` on `dout[7:0]` with `dout_oe` = 8'hFF, one clock after the strobe.
- R2: With `busy` high and `rd_addr` equal to `last_wr_addr`, `dout[7]` is the inverse of `last_wr_msb` and `dout_oe[7]` is 1.
- R3: With `busy` high and `rd_addr` different from `last_wr_addr`, `dout[7]` is 0 and `dout_oe[7]` is 0.
- R4: With `busy` high, `dout[6]` (with `dout_oe[6]` = 1) reads 0 on the first read of a write cycle. It then alternates 1, 0, 1 on the reads that follow.
- R5: A write cycle starts on a rising edge of `busy`. The toggle sequence restarts from 0 at every cycle start, whatever value it held at the end of the previous cycle, and even when no read falls on the starting clock.
- R6: With `busy` high, `dout[5]` equals `plt_expired` (0 while the load timer runs, 1 once it has expired), with `dout_oe[5]` = 1.
- R7: With `busy` high, `dout[4:0]` are 0 and `dout_oe[4:0]` are 0, and `array_data` has no effect on the reply.
- R8: After `busy` falls, a read of the last written address returns the stored byte unchanged, including its true bit 7.
- R9: After reset, `dout` and `dout_oe` are 0. Between strobes both hold their last value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rd_stb | input | 1 | One-cycle read request |
| rd_addr | input | ADDR_W | Address being read |
| last_wr_addr | input | ADDR_W | Address of the last byte written |
| last_wr_msb | input | 1 | Bit 7 of the last byte written |
| busy | input | 1 | Internal write cycle in progress |
| plt_expired | input | 1 | Page-load timer has expired |
| array_data | input | 8 | Normal array read data |
| dout | output | 8 | Reply byte |
| dout_oe | output | 8 | Per-bit drive enable of the reply |

## Verification
The bench aims first at the toggle bit at a write cycle's boundaries. A design that carried the toggle state over from one cycle to the next would return 1 on the first status read of the new cycle. A design that reset the state only on a read at the starting clock would fail when the host waits a few clocks before polling. It also reads a non-matching address while busy, where a design that polled regardless of address would drive an inverted bit 7. Finally, it reads the written byte again once busy has dropped. A design that kept the inversion latched would corrupt bit 7 of that read, and one that reopened the array path while busy would leak `array_data` onto the undriven low bits.

// File: rtl/wsr_pkg.sv
package wsr_pkg;
  localparam int DATA_W  = 8;
  localparam int POLL_POS = 7;
  localparam int TOG_POS  = 6;
  localparam int PLT_POS  = 5;
  localparam int LOW_W    = PLT_POS;

  typedef struct packed {
    logic [DATA_W-1:0] val;
    logic [DATA_W-1:0] oe;
  } rd_beat_t;

  function automatic rd_beat_t pass_beat(input logic [DATA_W-1:0] arr);
    rd_beat_t b;
    b.val = arr;
    b.oe  = '1;
    return b;
  endfunction

  function automatic rd_beat_t status_beat(input logic hit, input logic msb,
                                           input logic tog, input logic plt);
    rd_beat_t b;
    b.val = '0;
    b.oe  = '0;
    b.val[POLL_POS] = hit & ~msb;
    b.oe[POLL_POS]  = hit;
    b.val[TOG_POS]  = tog;
    b.oe[TOG_POS]   = 1'b1;
    b.val[PLT_POS]  = plt;
    b.oe[PLT_POS]   = 1'b1;
    return b;
  endfunction
endpackage

// File: rtl/wsr_cycle_tracker.sv
module wsr_cycle_tracker (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic cycle_start
);
  logic busy_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_q <= 1'b0;
    else        busy_q <= busy;
  end

  assign cycle_start = busy & ~busy_q;
endmodule

// File: rtl/wsr_toggle.sv
module wsr_toggle (
  input  logic clk,
  input  logic rst_n,
  input  logic cycle_start,
  input  logic rd_busy,
  output logic tog_now
);
  logic tog_q;

  assign tog_now = cycle_start ? 1'b0 : tog_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           tog_q <= 1'b0;
    else if (rd_busy)     tog_q <= ~tog_now;
    else if (cycle_start) tog_q <= 1'b0;
  end
endmodule

// File: rtl/wsr_byte_mux.sv
module wsr_byte_mux
  import wsr_pkg::*;
(
  input  logic              busy,
  input  logic              addr_hit,
  input  logic              last_wr_msb,
  input  logic              tog_now,
  input  logic              plt_expired,
  input  logic [DATA_W-1:0] array_data,
  output rd_beat_t          beat
);
  always_comb begin
    if (busy) beat = status_beat(addr_hit, last_wr_msb, tog_now, plt_expired);
    else      beat = pass_beat(array_data);
  end
endmodule

// File: rtl/wsr_out_reg.sv
module wsr_out_reg
  import wsr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  rd_beat_t          beat,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_oe
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dout    <= '0;
      dout_oe <= '0;
    end else if (load) begin
      dout    <= beat.val;
      dout_oe <= beat.oe;
    end
  end
endmodule

// File: rtl/wr_status_rpt.sv
module wr_status_rpt
  import wsr_pkg::*;
#(
  parameter int ADDR_W = 11
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_stb,
  input  logic [ADDR_W-1:0] rd_addr,
  input  logic [ADDR_W-1:0] last_wr_addr,
  input  logic              last_wr_msb,
  input  logic              busy,
  input  logic              plt_expired,
  input  logic [DATA_W-1:0] array_data,
  output logic [DATA_W-1:0] dout,
  output logic [DATA_W-1:0] dout_oe
);
  logic     cycle_start;
  logic     rd_busy;
  logic     addr_hit;
  logic     tog_now;
  rd_beat_t beat;

  assign rd_busy  = rd_stb & busy;
  assign addr_hit = (rd_addr == last_wr_addr);

  wsr_cycle_tracker u_trk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .cycle_start(cycle_start)
  );

  wsr_toggle u_tog (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .rd_busy(rd_busy), .tog_now(tog_now)
  );

  wsr_byte_mux u_mux (
    .busy(busy), .addr_hit(addr_hit), .last_wr_msb(last_wr_msb),
    .tog_now(tog_now), .plt_expired(plt_expired),
    .array_data(array_data), .beat(beat)
  );

  wsr_out_reg u_out (
    .clk(clk), .rst_n(rst_n), .load(rd_stb), .beat(beat),
    .dout(dout), .dout_oe(dout_oe)
  );
endmodule

// File: rtl/wr_status_rpt_chk.sv
module wr_status_rpt_chk #(
  parameter int ADDR_W = 11
) (
  input logic              clk,
  input logic              rst_n,
  input logic              rd_stb,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [ADDR_W-1:0] last_wr_addr,
  input logic              last_wr_msb,
  input logic              busy,
  input logic              plt_expired,
  input logic [7:0]        array_data,
  input logic [7:0]        dout,
  input logic [7:0]        dout_oe,
  input logic              cycle_start
);
  // independent expectation of the toggle sequence
  logic busy_seen;
  logic m_tog;
  logic m_cur;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) busy_seen <= 1'b0;
    else        busy_seen <= busy;
  end

  assign m_cur = (busy && !busy_seen) ? 1'b0 : m_tog;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                m_tog <= 1'b0;
    else if (rd_stb && busy)   m_tog <= ~m_cur;
    else if (busy && !busy_seen) m_tog <= 1'b0;
  end

  p_idle_pass_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && !busy |=> dout == $past(array_data) && dout_oe == 8'hFF);

  p_poll_inv_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy && rd_addr == last_wr_addr |=> dout[7] == !$past(last_wr_msb) && dout_oe[7]);

  p_poll_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy && rd_addr != last_wr_addr |=> !dout[7] && !dout_oe[7]);

  p_tog_seq_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy |=> dout[6] == $past(m_cur) && dout_oe[6]);

  p_tog_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && cycle_start |=> !dout[6]);

  p_timer_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy |=> dout[5] == $past(plt_expired) && dout_oe[5]);

  p_low_hiz_r7: assert property (@(posedge clk) disable iff (!rst_n)
    rd_stb && busy |=> dout_oe[4:0] == 5'd0 && dout[4:0] == 5'd0);

  p_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_stb |=> $stable(dout) && $stable(dout_oe));
endmodule

bind wr_status_rpt wr_status_rpt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
  .last_wr_addr(last_wr_addr), .last_wr_msb(last_wr_msb), .busy(busy),
  .plt_expired(plt_expired), .array_data(array_data), .dout(dout),
  .dout_oe(dout_oe), .cycle_start(cycle_start)
);

// File: tb/wr_status_rpt_test.sv
`timescale 1ns/1ps
module wr_status_rpt_test;
  localparam int AW = 11;
  localparam logic [AW-1:0] LAST_A = 11'h123;

  typedef struct packed {
    logic        busy;
    logic [10:0] addr;
    logic [7:0]  arr;
    logic        msb;
    logic        plt;
    logic [7:0]  exp_d;
    logic [7:0]  exp_oe;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 9;
  localparam vec_t VECS [NV] = '{
    '{1'b0, 11'h010, 8'h3C, 1'b0, 1'b0, 8'h3C, 8'hFF, 4'd1},
    '{1'b0, 11'h123, 8'hA5, 1'b0, 1'b0, 8'hA5, 8'hFF, 4'd1},
    '{1'b1, 11'h123, 8'hFF, 1'b0, 1'b0, 8'h80, 8'hE0, 4'd2},
    '{1'b1, 11'h123, 8'hFF, 1'b0, 1'b0, 8'hC0, 8'hE0, 4'd4},
    '{1'b1, 11'h050, 8'hFF, 1'b0, 1'b1, 8'h20, 8'h60, 4'd3},
    '{1'b0, 11'h123, 8'h5A, 1'b0, 1'b0, 8'h5A, 8'hFF, 4'd8},
    '{1'b1, 11'h123, 8'h1F, 1'b1, 1'b0, 8'h00, 8'hE0, 4'd5},
    '{1'b1, 11'h123, 8'h1F, 1'b1, 1'b1, 8'h60, 8'hE0, 4'd6},
    '{1'b0, 11'h123, 8'hDA, 1'b1, 1'b0, 8'hDA, 8'hFF, 4'd8}
  };

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          rd_stb = 1'b0;
  logic [AW-1:0] rd_addr = '0;
  logic [AW-1:0] last_wr_addr = LAST_A;
  logic          last_wr_msb = 1'b0;
  logic          busy = 1'b0;
  logic          plt_expired = 1'b0;
  logic [7:0]    array_data = '0;
  logic [7:0]    dout, dout_oe;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  wr_status_rpt #(.ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .rd_stb(rd_stb), .rd_addr(rd_addr),
    .last_wr_addr(last_wr_addr), .last_wr_msb(last_wr_msb), .busy(busy),
    .plt_expired(plt_expired), .array_data(array_data),
    .dout(dout), .dout_oe(dout_oe)
  );

  task automatic check(input string req, input logic [7:0] ed, input logic [7:0] eo);
    checks++;
    if (dout !== ed || dout_oe !== eo) begin
      errors++;
      $display("FAIL %s: dout=%h oe=%h expected dout=%h oe=%h", req, dout, dout_oe, ed, eo);
    end
  endtask

  task automatic do_read(input logic [AW-1:0] a);
    @(negedge clk);
    rd_addr = a;
    rd_stb  = 1'b1;
    @(negedge clk);
    rd_stb  = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9 reset", 8'h00, 8'h00);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R9 reset released", 8'h00, 8'h00);

    // vector table: R1 R2 R3 R4 R5 R6 R7 R8
    foreach (VECS[i]) begin
      busy        = VECS[i].busy;
      array_data  = VECS[i].arr;
      last_wr_msb = VECS[i].msb;
      plt_expired = VECS[i].plt;
      do_read(VECS[i].addr);
      check($sformatf("R%0d vec %0d (R7 low bits)", VECS[i].req, i), VECS[i].exp_d, VECS[i].exp_oe);
    end

    // R9: hold between strobes
    busy = 1'b1; array_data = 8'h00; plt_expired = 1'b1; rd_addr = 11'h7FF;
    repeat (4) @(negedge clk);
    check("R9 hold", 8'hDA, 8'hFF);
    busy = 1'b0;
    @(negedge clk);

    // R5: restart without read on starting clock, after toggle left at 1
    last_wr_msb = 1'b0; plt_expired = 1'b0;
    @(negedge clk); busy = 1'b1;
    do_read(LAST_A); check("R4 seq a", 8'h80, 8'hE0);
    do_read(LAST_A); check("R4 seq b", 8'hC0, 8'hE0);
    do_read(LAST_A); check("R4 seq c", 8'h80, 8'hE0);
    busy = 1'b0;
    repeat (2) @(negedge clk);
    busy = 1'b1;
    repeat (3) @(negedge clk);
    do_read(LAST_A); check("R5 restart no read", 8'h80, 8'hE0);
    do_read(11'h000); check("R3 miss addr", 8'h40, 8'h60);

    // R7: array data ignored while busy
    array_data = 8'h1F;
    do_read(LAST_A); check("R7 array ignored", 8'h80, 8'hE0);
    busy = 1'b0;
    array_data = 8'h7E;
    do_read(LAST_A); check("R8 true data", 8'h7E, 8'hFF);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule